// File: doc/BRIEF.md
# SPI Flash Command Engine with Shared Ring Buffer

This block is a memory-mapped SPI master that runs a single serial-flash command at a time. Software loads an opcode, a byte that packs how many bytes to send and how many to receive, and the bytes to send. The bytes to send go in one at a time through a data port that steps an internal pointer. Software then sets an execute bit and polls it until the engine clears it.

The engine asserts chip select and shifts out the opcode directly from its register. It then sends the queued bytes and clocks in the response. Send and receive share one 8-slot ring buffer. Each slot used for an outgoing byte is overwritten with the byte that arrived while it was being sent. Bytes that are only received go into the slots after it. The ring is never cleared, so software resets the pointer and reads everything back through the same data port.

A two-bit speed field picks the serial clock divider. The bus runs in SPI mode 0.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, the registers at offsets 0x0, 0x1, 0x2 and 0xD read 0x00, `spi_cs_n` is high and `spi_sclk` is low.
- R2: The opcode register at offset 0x0 is the first byte shifted out, MSB first, in every command. It never occupies a ring slot.
- R3: Offset 0x1 holds the receive count in bits 7:4 and the send count (opcode excluded) in bits 3:0. It reads back unchanged after a command.
- R4: Writing a 1 to bit 0 of offset 0x2 starts a command. The bit reads 1 while the command runs and 0 once it has completed.
- R5: Writing a 1 to bit 4 of offset 0x2 sets the ring pointer to 0. The pointer reads back in bits 2:0 of offset 0xD. When bits 4 and 0 are set in one write, the command starts from pointer 0.
- R6: Every read or write of the data port at offset 0xC accesses the slot at the pointer. It then advances the pointer by one, modulo 8.
- R7: Send bytes come from consecutive slots starting at the pointer, and each of those slots is overwritten with the byte received at the same time. Received-only bytes fill the following slots while MOSI carries 0xFF. Afterwards the pointer equals its start value plus the send count plus the receive count, modulo 8.
- R8: An opcode-only command with a nonzero receive count clocks exactly the requested number of response bytes, and the last response byte is not dropped.
- R9: Speed field bits 5:4 of offset 0xD set the SCLK period to 2, 4, 6 or 8 system clocks for the values 0, 1, 2 and 3.
- R10: The bus runs in SPI mode 0. SCLK idles low. MOSI changes only while SCLK is low. MISO is sampled on the rising edge.
- R11: `spi_cs_n` stays low from before the first opcode bit until after the last received bit, and is high whenever no command is running.
- R12: Every register write, and every read of the data port, is ignored while a command is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (steps the pointer at offset 0xC) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The engine's own ring update and a host access can fall in the same cycle. Examples are a data-port write landing in the cycle where a received byte is stored, or a count-register write in the cycle where the execute bit drops. The bench provokes these collisions with back-to-back writes to the count, opcode, control and data-port offsets issued right after the start. It judges the outcome afterwards through the count and opcode readback and the pointer value, which any accepted access would have shifted. The full sweep of send and receive counts also drives the ring past its wrap point, so the engine's writes overtake slots it has already stored.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_OPC,
      SQ_DATA
   } seq_t;

   localparam logic [3:0] OFS_OPC  = 4'h0;
   localparam logic [3:0] OFS_CNT  = 4'h1;
   localparam logic [3:0] OFS_CTL  = 4'h2;
   localparam logic [3:0] OFS_DATA = 4'hC;
   localparam logic [3:0] OFS_STAT = 4'hD;

   localparam int CTL_GO_BIT  = 0;
   localparam int CTL_CLR_BIT = 4;

   localparam logic [7:0] IDLE_FILL = 8'hFF;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] half_len,
   output logic             tick
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == CNT_W'(half_len - 1'b1));
   assign tick   = run && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (at_end) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
   parameter int BITS  = 8,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [BITS-1:0]  tx_byte,
   input  logic [CNT_W-1:0] half_len,
   input  logic             miso,
   output logic             sclk,
   output logic             mosi,
   output logic             done,
   output logic [BITS-1:0]  rx_byte
);
   localparam int BIT_W = $clog2(BITS);

   logic             active_q;
   logic [BITS-1:0]  sh_q;
   logic [BITS-1:0]  rx_q;
   logic [BIT_W-1:0] bitn_q;
   logic             sclk_q;
   logic             done_q;
   logic             tick;

   spi_half_tick #(.CNT_W(CNT_W)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (active_q),
      .half_len (half_len),
      .tick     (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sh_q     <= '0;
         rx_q     <= '0;
         bitn_q   <= '0;
         sclk_q   <= 1'b0;
         done_q   <= 1'b0;
      end else if (start) begin
         active_q <= 1'b1;
         sh_q     <= tx_byte;
         bitn_q   <= '0;
         sclk_q   <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (active_q && tick) begin
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rx_q   <= {rx_q[BITS-2:0], miso};
            end else begin
               sclk_q <= 1'b0;
               if (bitn_q == BIT_W'(BITS - 1)) begin
                  active_q <= 1'b0;
                  done_q   <= 1'b1;
               end else begin
                  bitn_q <= bitn_q + 1'b1;
                  sh_q   <= {sh_q[BITS-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign sclk    = sclk_q;
   assign mosi    = sh_q[BITS-1];
   assign done    = done_q;
   assign rx_byte = rx_q;
endmodule

// File: rtl/spi_ring.sv
module spi_ring #(
   parameter int DEPTH          = 8,
   parameter int W              = 8,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     adv,
   input  logic                     wr_en,
   input  logic [W-1:0]             wdata,
   output logic [$clog2(DEPTH)-1:0] ptr,
   output logic [W-1:0]             rd_cur,
   output logic [W-1:0]             rd_nxt
);
   localparam int PTR_W = $clog2(DEPTH);

   logic [W-1:0]     slot_q [DEPTH];
   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_inc;

   assign ptr_inc = PTR_W'(ptr_q + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr_q <= '0;
      else if (clr) ptr_q <= '0;
      else if (adv) ptr_q <= ptr_inc;
   end

   generate
      if (CLEAR_ON_RESET) begin : g_rst_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            end else if (wr_en) begin
               slot_q[ptr_q] <= wdata;
            end
         end
      end else begin : g_plain_store
         always_ff @(posedge clk) begin
            if (wr_en) slot_q[ptr_q] <= wdata;
         end
      end
   endgenerate

   assign ptr    = ptr_q;
   assign rd_cur = slot_q[ptr_q];
   assign rd_nxt = slot_q[ptr_inc];
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_eng_pkg::*;
#(
   parameter int  RING_DEPTH     = 8,
   parameter int  SPEED_W        = 2,
   parameter bit  CLEAR_ON_RESET = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] reg_addr,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       spi_sclk,
   output logic       spi_cs_n,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   localparam int PTR_W  = $clog2(RING_DEPTH);
   localparam int HALF_W = SPEED_W + 1;
   localparam int LEFT_W = 5;

   generate
      if (RING_DEPTH != (1 << PTR_W) || PTR_W > 3 || PTR_W < 1) begin : g_bad_depth
         $error("RING_DEPTH must be a power of two from 2 to 8");
      end
      if (SPEED_W != 2) begin : g_bad_speed
         $error("SPEED_W must be 2 to fit bits 5:4 of the status register");
      end
   endgenerate

   logic [7:0]         op_q, cnt_q, kick_byte_q;
   logic [SPEED_W-1:0] speed_q;
   logic               exec_q, cs_q, kick_q;
   logic [LEFT_W-1:0]  left_q;
   logic [3:0]         txleft_q;
   seq_t               state_q;

   logic               host_ok, wr_hit_ctl, go, ptr_clr;
   logic               host_data_wr, host_data_rd, eng_store;
   logic [PTR_W-1:0]   ring_ptr;
   logic [7:0]         ring_cur, ring_nxt, sh_rx;
   logic               sh_done;
   logic [HALF_W-1:0]  half_len;

   assign host_ok      = !exec_q;
   assign wr_hit_ctl   = reg_wr && host_ok && (reg_addr == OFS_CTL);
   assign go           = wr_hit_ctl && reg_wdata[CTL_GO_BIT];
   assign ptr_clr      = wr_hit_ctl && reg_wdata[CTL_CLR_BIT];
   assign host_data_wr = reg_wr && host_ok && (reg_addr == OFS_DATA);
   assign host_data_rd = reg_rd && host_ok && (reg_addr == OFS_DATA);
   assign eng_store    = sh_done && (state_q == SQ_DATA);
   assign half_len     = HALF_W'(speed_q) + 1'b1;

   spi_ring #(.DEPTH(RING_DEPTH), .W(8), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_ring (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ptr_clr),
      .adv    (host_data_wr | host_data_rd | eng_store),
      .wr_en  (host_data_wr | eng_store),
      .wdata  (eng_store ? sh_rx : reg_wdata),
      .ptr    (ring_ptr),
      .rd_cur (ring_cur),
      .rd_nxt (ring_nxt)
   );

   spi_byte_shifter #(.BITS(8), .CNT_W(HALF_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (kick_q),
      .tx_byte  (kick_byte_q),
      .half_len (half_len),
      .miso     (spi_miso),
      .sclk     (spi_sclk),
      .mosi     (spi_mosi),
      .done     (sh_done),
      .rx_byte  (sh_rx)
   );

   // host-visible configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= '0;
         cnt_q   <= '0;
         speed_q <= '0;
      end else if (reg_wr && host_ok) begin
         case (reg_addr)
            OFS_OPC:  op_q    <= reg_wdata;
            OFS_CNT:  cnt_q   <= reg_wdata;
            OFS_STAT: speed_q <= reg_wdata[5:4];
            default:  ;
         endcase
      end
   end

   // command sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         exec_q      <= 1'b0;
         cs_q        <= 1'b1;
         kick_q      <= 1'b0;
         kick_byte_q <= '0;
         left_q      <= '0;
         txleft_q    <= '0;
      end else begin
         kick_q <= 1'b0;
         case (state_q)
            SQ_IDLE: if (go) begin
               exec_q      <= 1'b1;
               cs_q        <= 1'b0;
               kick_q      <= 1'b1;
               kick_byte_q <= op_q;
               txleft_q    <= cnt_q[3:0];
               left_q      <= LEFT_W'(cnt_q[7:4]) + LEFT_W'(cnt_q[3:0]);
               state_q     <= SQ_OPC;
            end
            SQ_OPC: if (sh_done) begin
               if (left_q == '0) begin
                  exec_q  <= 1'b0;
                  cs_q    <= 1'b1;
                  state_q <= SQ_IDLE;
               end else begin
                  kick_q      <= 1'b1;
                  kick_byte_q <= (txleft_q != '0) ? ring_cur : IDLE_FILL;
                  state_q     <= SQ_DATA;
               end
            end
            SQ_DATA: if (sh_done) begin
               left_q <= left_q - 1'b1;
               if (txleft_q != '0) txleft_q <= txleft_q - 1'b1;
               if (left_q == LEFT_W'(1)) begin
                  exec_q  <= 1'b0;
                  cs_q    <= 1'b1;
                  state_q <= SQ_IDLE;
               end else begin
                  kick_q      <= 1'b1;
                  kick_byte_q <= (txleft_q > 4'd1) ? ring_nxt : IDLE_FILL;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign spi_cs_n = cs_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_OPC:  reg_rdata = op_q;
         OFS_CNT:  reg_rdata = cnt_q;
         OFS_CTL:  reg_rdata = {7'd0, exec_q};
         OFS_DATA: reg_rdata = ring_cur;
         OFS_STAT: reg_rdata = {2'b00, speed_q, 1'b0, 3'(ring_ptr)};
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
   parameter int PTR_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             exec_busy,
   input logic             cs_n,
   input logic             sclk,
   input logic             mosi,
   input logic [PTR_W-1:0] ptr,
   input logic [7:0]       cnt_val
);
   AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_busy |-> cs_n); // R11

   AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk); // R10

   AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi)); // R10

   AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_busy && $past(exec_busy)) |-> $stable(cnt_val)); // R12

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr != $past(ptr)) |-> (ptr == PTR_W'($past(ptr) + 1'b1) || ptr == '0)); // R6

   AST_CS_OPENS_WITH_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> exec_busy); // R4
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .exec_busy (exec_q),
   .cs_n      (spi_cs_n),
   .sclk      (spi_sclk),
   .mosi      (spi_mosi),
   .ptr       (ring_ptr),
   .cnt_val   (cnt_q)
);

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       spi_sclk, spi_cs_n, spi_mosi;
   logic       spi_miso = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   spi_cmd_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // ---------------- flash model ----------------
   logic [7:0] mrx [0:63];
   int         mcount = 0;
   int         bitc = 0;
   int         idx = 0;
   logic [7:0] shin = '0;
   logic [7:0] first_op = '0;

   function automatic logic [7:0] resp(input logic [7:0] op, input int i);
      if (i == 0) return 8'hC3;
      return op ^ 8'(i * 37 + 5);
   endfunction

   function automatic logic [7:0] txdat(input logic [7:0] op, input int t);
      return op + 8'(t * 13 + 1);
   endfunction

   always @(negedge spi_cs_n) begin
      logic [7:0] r;
      bitc = 0; idx = 0; mcount = 0;
      r = resp(8'h00, 0);
      spi_miso = r[7];
   end

   always @(posedge spi_sclk) if (!spi_cs_n) begin
      shin = {shin[6:0], spi_mosi};
      bitc++;
   end

   always @(negedge spi_sclk) if (!spi_cs_n) begin
      logic [7:0] r;
      if (bitc == 8) begin
         if (mcount < 64) mrx[mcount] = shin;
         if (mcount == 0) first_op = shin;
         mcount++; idx++; bitc = 0;
      end
      r = resp(first_op, idx);
      spi_miso = r[7 - bitc];
   end

   // ---------------- SCLK period monitor ----------------
   int cyc = 0;
   int last_rise = 0;
   int min_per = 1000;
   always @(posedge clk) cyc++;
   always @(posedge spi_sclk) begin
      if (cyc - last_rise < min_per) min_per = cyc - last_rise;
      last_rise = cyc;
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic run_cmd(input logic [7:0] op, input int tx, input int rx,
                          input int spd, input bit poke);
      logic [7:0] v;
      int n;
      n = tx + rx;
      wr(4'hD, 8'(spd << 4));
      wr(4'h0, op);
      wr(4'h1, 8'((rx << 4) | tx));
      wr(4'h2, 8'h10);
      for (int t = 0; t < tx; t++) wr(4'hC, txdat(op, t));
      rd(4'hD, v);
      chk("R6 ptr after loading", int'(v[2:0]), tx % 8);
      min_per = 1000;
      wr(4'h2, 8'h11);
      if (poke) begin
         wr(4'h1, 8'hFF);
         wr(4'hC, 8'hAA);
         wr(4'h2, 8'h10);
         wr(4'h0, 8'h00);
         wr(4'hD, 8'h30);
         rd(4'hC, v);
      end
      rd(4'h2, v);
      chk("R4 busy after start", int'(v[0]), 1);
      while (v[0]) rd(4'h2, v);
      chk("R11 cs high when done", int'(spi_cs_n), 1);
      rd(4'h1, v);
      chk("R3 count readback", int'(v), (rx << 4) | tx);
      rd(4'h0, v);
      chk("R12 opcode untouched", int'(v), int'(op));
      rd(4'hD, v);
      chk("R7 final pointer", int'(v[2:0]), n % 8);
      chk("R12 speed untouched", int'(v[5:4]), spd);
      chk("R8 bytes on bus", mcount, 1 + n);
      chk("R2 opcode first", int'(mrx[0]), int'(op));
      for (int t = 0; t < tx; t++) chk("R7 send byte", int'(mrx[1 + t]), int'(txdat(op, t)));
      for (int k = 0; k < rx; k++) chk("R7 fill byte", int'(mrx[1 + tx + k]), 8'hFF);
      if (n > 0) chk("R9 sclk period", min_per, 2 * (spd + 1));
      wr(4'h2, 8'h10);
      for (int k = 0; k < n; k++) begin
         int s, jmax;
         s = k % 8;
         jmax = s + 8 * ((n - 1 - s) / 8);
         rd(4'hC, v);
         chk("R7 ring content", int'(v), int'(resp(op, jmax + 1)));
      end
      rd(4'hD, v);
      chk("R6 ptr after readback", int'(v[2:0]), n % 8);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- main ----------------
   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(4'h0, v); chk("R1 opcode reset", int'(v), 0);
      rd(4'h1, v); chk("R1 count reset", int'(v), 0);
      rd(4'h2, v); chk("R1 control reset", int'(v), 0);
      rd(4'hD, v); chk("R1 status reset", int'(v), 0);
      chk("R1 cs idle", int'(spi_cs_n), 1);
      chk("R1 sclk idle", int'(spi_sclk), 0);

      // R5: clear in one write with a pointer already moved
      wr(4'hC, 8'h11); wr(4'hC, 8'h22);
      rd(4'hD, v); chk("R6 ptr steps on write", int'(v[2:0]), 2);
      wr(4'h2, 8'h10);
      rd(4'hD, v); chk("R5 ptr cleared", int'(v[2:0]), 0);
      rd(4'hC, v); chk("R6 read slot 0", int'(v), 8'h11);
      rd(4'hC, v); chk("R6 read slot 1", int'(v), 8'h22);

      // sweep of send and receive counts at the fastest clock (R7, R8)
      for (int tx = 0; tx <= 8; tx++)
         for (int rx = 0; rx <= 15; rx++)
            run_cmd(8'(8'h40 + tx * 16 + rx), tx, rx, 0, 1'b0);

      // other speeds, with writes during the busy window (R9, R12)
      for (int s = 1; s < 4; s++) run_cmd(8'(8'h9A + s), 3, 2, s, 1'b1);
      run_cmd(8'h05, 0, 1, 3, 1'b1);
      run_cmd(8'h9F, 0, 15, 1, 1'b1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule